// File: doc/BRIEF.md
# BCD Real-Time Calendar Clock Core

This core keeps wall-clock time and the calendar as packed BCD fields: seconds, minutes, hours, date, month, weekday, year and century. It advances by one second on each single-cycle pulse of a one-pulse-per-second input. Software reaches it through a simple register bus with a combinational read path. A single level interrupt reports enabled events.

Software cannot overwrite the running time or calendar at will. It first sets a request bit for the time group, the calendar group or both. That bit freezes the matching counters at once. On the next second pulse the core acknowledges the request in its status word, and only then does it accept new values. Clearing both request bits lets counting resume on the following pulse. Day rollover follows month lengths and a leap-year rule that also covers the century year.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time word reads 0x00000000 and the calendar word reads 0x01210020 (date 01, weekday 1, month 01, year 00, century 20). Control, status and mask all read 0, and irq_o is low.
- R2: Each second pulse advances the seconds in BCD. Seconds 59 wrap to 00 and carry into minutes, minutes 59 wrap and carry into hours, and hours 23 wrap to 00 and carry into the calendar. Time word layout: seconds in bits 6:0, minutes in 14:8, hours in 21:16.
- R3: Writing control (offset 0x00) bit 0 freezes the time counters and bit 1 freezes the calendar counters at once. Status bit 0 (acknowledge) sets on the first second pulse after a request bit is set.
- R4: Writes to time (0x08) or calendar (0x0C) are ignored unless the matching request bit is set and the acknowledge for the current request has happened.
- R5: After both request bits are cleared, the next second pulse advances the time again.
- R6: A day rollover applies month lengths (30 days for months 04, 06, 09 and 11; 28 or 29 for month 02; 31 otherwise). A year is a leap year when its BCD value is divisible by 4, and year 00 also needs a century divisible by 4. Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and increments the century. Weekday 7 wraps to 1. Calendar layout: century 6:0, year 15:8, month 20:16, weekday 23:21, date 29:24.
- R7: Status bit 2 sets on every pulse that advances the seconds, bit 3 on each minute rollover, and bit 4 on each day rollover. Bit 1 never sets in this core.
- R8: Writing 1s to status-clear (0x1C) clears those status bits (status reads at 0x18). Writing 0s leaves the status unchanged.
- R9: Writing 1s to 0x20 sets mask bits and writing 1s to 0x24 clears them. The mask reads back at 0x28.
- R10: irq_o is high exactly when some status bit and its mask bit are both 1.
- R11: The mode register (0x04) always reads 0, which is the 24-hour format. The AM/PM bit (time bit 22) always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse once per second |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte offset of the register |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted BCD digit or a wrong carry shows up in the time or calendar word at the next read after the pulse that exercised it. Because of this, each rollover case is loaded one second before its boundary and read after a single pulse. A broken handshake shows up in one of two ways: counting continues during a freeze, or a load lands before the acknowledge. Both are visible within one pulse. Errors in the status or mask bits show on irq_o in the cycle after the register write.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_MODE = 'h04;
  localparam int OFF_TIME = 'h08;
  localparam int OFF_CAL  = 'h0C;
  localparam int OFF_STAT = 'h18;
  localparam int OFF_SCLR = 'h1C;
  localparam int OFF_IEN  = 'h20;
  localparam int OFF_IDIS = 'h24;
  localparam int OFF_IMSK = 'h28;

  localparam int NEVT   = 5;
  localparam int EV_ACK = 0;
  localparam int EV_ALM = 1;
  localparam int EV_SEC = 2;
  localparam int EV_TIM = 3;
  localparam int EV_CAL = 4;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
    logic [7:0] yb, cb;
    yb = bcd_bin(yr);
    cb = bcd_bin(cen);
    return (yb[1:0] == 2'd0) && ((yr != 8'h00) || (cb[1:0] == 2'd0));
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap_cnt.sv
module rtc_bcd_wrap_cnt #(
  parameter int           W   = 8,
  parameter logic [W-1:0] LO  = '0,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  import rtc_bcd_pkg::*;

  logic [W-1:0] val_q;

  // >= keeps an out-of-range loaded value from running away
  assign wrap_o = inc_i && (val_q >= hi_i);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= wrap_o ? LO : W'(bcd_inc(8'(val_q)));
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain #(
  parameter int NF = 3,
  parameter int FW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           load_i,
  input  logic [NF*FW-1:0] load_val_i,
  output logic [NF*FW-1:0] val_o,
  output logic           min_wrap_o,
  output logic           day_wrap_o
);
  logic [NF:0]   carry;
  logic [NF-1:0] wrap;

  assign carry[0] = step_i;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam logic [FW-1:0] HI = (g == NF - 1) ? FW'(8'h23) : FW'(8'h59);
    rtc_bcd_wrap_cnt #(.W(FW), .LO('0), .RST('0)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (carry[g]),
      .load_i     (load_i),
      .load_val_i (load_val_i[g*FW +: FW]),
      .hi_i       (HI),
      .val_o      (val_o[g*FW +: FW]),
      .wrap_o     (wrap[g])
    );
    assign carry[g+1] = wrap[g];
  end

  assign min_wrap_o = carry[1];
  assign day_wrap_o = carry[NF];
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain #(
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          day_i,
  input  logic          load_i,
  input  logic [FW-1:0] ld_date_i,
  input  logic [FW-1:0] ld_mon_i,
  input  logic [FW-1:0] ld_year_i,
  input  logic [FW-1:0] ld_cen_i,
  input  logic [FW-1:0] ld_wday_i,
  output logic [FW-1:0] date_o,
  output logic [FW-1:0] mon_o,
  output logic [FW-1:0] year_o,
  output logic [FW-1:0] cen_o,
  output logic [FW-1:0] wday_o
);
  import rtc_bcd_pkg::*;

  logic          date_wrap, mon_wrap, year_wrap, cen_wrap, wday_wrap;
  logic [FW-1:0] date_hi;

  assign date_hi = FW'(month_last(8'(mon_o), is_leap(8'(year_o), 8'(cen_o))));

  rtc_bcd_wrap_cnt #(.W(FW), .LO(FW'(1)), .RST(FW'(1))) u_date (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(day_i), .load_i(load_i),
    .load_val_i(ld_date_i), .hi_i(date_hi), .val_o(date_o), .wrap_o(date_wrap));

  rtc_bcd_wrap_cnt #(.W(FW), .LO(FW'(1)), .RST(FW'(1))) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(date_wrap), .load_i(load_i),
    .load_val_i(ld_mon_i), .hi_i(FW'(8'h12)), .val_o(mon_o), .wrap_o(mon_wrap));

  rtc_bcd_wrap_cnt #(.W(FW), .LO('0), .RST('0)) u_year (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(mon_wrap), .load_i(load_i),
    .load_val_i(ld_year_i), .hi_i(FW'(8'h99)), .val_o(year_o), .wrap_o(year_wrap));

  rtc_bcd_wrap_cnt #(.W(FW), .LO('0), .RST(FW'(8'h20))) u_cen (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(year_wrap), .load_i(load_i),
    .load_val_i(ld_cen_i), .hi_i(FW'(8'h79)), .val_o(cen_o), .wrap_o(cen_wrap));

  rtc_bcd_wrap_cnt #(.W(FW), .LO(FW'(1)), .RST(FW'(1))) u_wday (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(day_i), .load_i(load_i),
    .load_val_i(ld_wday_i), .hi_i(FW'(7)), .val_o(wday_o), .wrap_o(wday_wrap));

  logic unused_wrap;
  assign unused_wrap = cen_wrap ^ wday_wrap;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ien_i,
  input  logic [N-1:0] idis_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;  // new event wins over clear
      mask_q   <= (mask_q | ien_i) & ~idis_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  import rtc_bcd_pkg::*;

  localparam int FW = 8;
  localparam int NF = 3;

  logic [1:0]      ctrl_q;
  logic            ack_done_q;
  logic            ack_set;
  logic            wr, rd;
  logic            ld_time, ld_cal;
  logic            step_t, day_inc, min_wrap, day_wrap;
  logic [NF*FW-1:0] t_val, t_load;
  logic [FW-1:0]   date, mon, year, cen, wday;
  logic [31:0]     time_word, cal_word, wd32;
  logic [NEVT-1:0] status, mask, ev_set, ev_clr, ev_ien, ev_idis;
  logic [31:0]     rd_word;

  assign wd32 = 32'(bus_wdata_i);
  assign wr   = bus_req_i && bus_we_i;
  assign rd   = bus_req_i && !bus_we_i;

  // request handshake
  assign ack_set = tick_i && (ctrl_q != 2'b00) && !ack_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      ack_done_q <= 1'b0;
    end else begin
      if (wr && bus_addr_i == AW'(OFF_CTRL)) ctrl_q <= wd32[1:0];
      if (ctrl_q == 2'b00) ack_done_q <= 1'b0;
      else if (ack_set)    ack_done_q <= 1'b1;
    end
  end

  assign ld_time = wr && (bus_addr_i == AW'(OFF_TIME)) && ctrl_q[0] && ack_done_q;
  assign ld_cal  = wr && (bus_addr_i == AW'(OFF_CAL))  && ctrl_q[1] && ack_done_q;

  // counting chains
  assign step_t  = tick_i && !ctrl_q[0];
  assign day_inc = day_wrap && !ctrl_q[1];
  assign t_load  = {2'b00, wd32[21:16], 1'b0, wd32[14:8], 1'b0, wd32[6:0]};

  rtc_time_chain #(.NF(NF), .FW(FW)) u_time (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_t),
    .load_i     (ld_time),
    .load_val_i (t_load),
    .val_o      (t_val),
    .min_wrap_o (min_wrap),
    .day_wrap_o (day_wrap)
  );

  rtc_date_chain #(.FW(FW)) u_date (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .day_i     (day_inc),
    .load_i    (ld_cal),
    .ld_date_i ({2'b00, wd32[29:24]}),
    .ld_mon_i  ({3'b000, wd32[20:16]}),
    .ld_year_i (wd32[15:8]),
    .ld_cen_i  ({1'b0, wd32[6:0]}),
    .ld_wday_i ({5'b00000, wd32[23:21]}),
    .date_o    (date),
    .mon_o     (mon),
    .year_o    (year),
    .cen_o     (cen),
    .wday_o    (wday)
  );

  assign time_word = {10'd0, t_val[21:16], 1'b0, t_val[14:8], 1'b0, t_val[6:0]};
  assign cal_word  = {2'b00, date[5:0], wday[2:0], mon[4:0], year, 1'b0, cen[6:0]};

  // events and interrupt
  always_comb begin
    ev_set         = '0;
    ev_set[EV_ACK] = ack_set;
    ev_set[EV_ALM] = 1'b0;
    ev_set[EV_SEC] = step_t;
    ev_set[EV_TIM] = min_wrap;
    ev_set[EV_CAL] = day_inc;
  end

  assign ev_clr  = (wr && bus_addr_i == AW'(OFF_SCLR)) ? wd32[NEVT-1:0] : '0;
  assign ev_ien  = (wr && bus_addr_i == AW'(OFF_IEN))  ? wd32[NEVT-1:0] : '0;
  assign ev_idis = (wr && bus_addr_i == AW'(OFF_IDIS)) ? wd32[NEVT-1:0] : '0;

  rtc_irq_ctrl #(.N(NEVT)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ev_set),
    .clr_i    (ev_clr),
    .ien_i    (ev_ien),
    .idis_i   (ev_idis),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  // read path; mode and write-only offsets read 0
  always_comb begin
    rd_word = '0;
    if (rd) begin
      case (bus_addr_i)
        AW'(OFF_CTRL): rd_word = {30'd0, ctrl_q};
        AW'(OFF_TIME): rd_word = time_word;
        AW'(OFF_CAL):  rd_word = cal_word;
        AW'(OFF_STAT): rd_word = 32'(status);
        AW'(OFF_IMSK): rd_word = 32'(mask);
        default:       rd_word = '0;
      endcase
    end
  end

  assign bus_rdata_o = DW'(rd_word);

  logic unused_bits;
  assign unused_bits = ^{bus_wdata_i, t_val[23:22], t_val[15], t_val[7],
                         date[7:6], mon[7:5], cen[7], wday[7:3]};
endmodule

// File: rtl/rtc_bcd_sva.sv
module rtc_bcd_sva #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int N  = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic          irq_o,
  input logic [1:0]    ctrl_q,
  input logic          ld_time,
  input logic [31:0]   time_word,
  input logic [N-1:0]  status,
  input logic [N-1:0]  mask
);
  import rtc_bcd_pkg::*;

  p_freeze_time_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[0] && !ld_time) |=> $stable(time_word));

  p_ack_after_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[EV_ACK]) |-> ($past(ctrl_q) != 2'b00));

  p_min_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[EV_TIM]) |-> (time_word[6:0] == 7'h00));

  p_day_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status[EV_CAL]) |-> (time_word[21:0] == 22'd0));

  p_mask_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == AW'(OFF_IEN))
    |=> ((mask & $past(bus_wdata_i[N-1:0])) == $past(bus_wdata_i[N-1:0])));

  p_mask_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == AW'(OFF_IDIS))
    |=> ((mask & $past(bus_wdata_i[N-1:0])) == '0));

  p_no_irq_unmasked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
endmodule

bind rtc_bcd_core rtc_bcd_sva #(.AW(AW), .DW(DW), .N(rtc_bcd_pkg::NEVT)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .ctrl_q      (ctrl_q),
  .ld_time     (ld_time),
  .time_word   (time_word),
  .status      (status),
  .mask        (mask)
);

// File: tb/tb_rtc_bcd_core.sv
module tb_rtc_bcd_core;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  rtc_bcd_core #(.AW(AW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  // monitor: sample reads late in the cycle, compare with scoreboard
  always @(negedge clk) begin
    #3;
    if (req && !we) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_err++;
        $display("FAIL unexpected read: got %h expected none", rdata);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          n_err++;
          $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_exp(input int a, input logic [31:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_err++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, e);
    end
  endtask

  task automatic load_all(input logic [31:0] t, input logic [31:0] c);
    wr_reg('h00, 32'h3);
    pulse();
    wr_reg('h08, t);
    wr_reg('h0C, c);
    wr_reg('h00, 32'h0);
    wr_reg('h1C, 32'h1F);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_exp('h08, 32'h0000_0000, "R1 time");
    rd_exp('h0C, 32'h0121_0020, "R1 calendar");
    rd_exp('h00, 32'h0, "R1 control");
    rd_exp('h18, 32'h0, "R1 status");
    rd_exp('h28, 32'h0, "R1 mask");
    chk_irq(1'b0, "R1");

    // R2 / R7 one second
    pulse();
    rd_exp('h08, 32'h0000_0001, "R2 second step");
    rd_exp('h18, 32'h04, "R7 second event");
    // R8 clear semantics
    wr_reg('h1C, 32'h0);
    rd_exp('h18, 32'h04, "R8 zero clear no effect");
    wr_reg('h1C, 32'h04);
    rd_exp('h18, 32'h00, "R8 one clears");

    // R4 load without handshake
    wr_reg('h08, 32'h0012_3456);
    wr_reg('h0C, 32'h1522_1020);
    rd_exp('h08, 32'h0000_0001, "R4 time write ignored");
    rd_exp('h0C, 32'h0121_0020, "R4 calendar write ignored");

    // R3 handshake
    wr_reg('h00, 32'h3);
    rd_exp('h00, 32'h3, "R3 control readback");
    rd_exp('h18, 32'h00, "R3 no ack before pulse");
    pulse();
    rd_exp('h18, 32'h01, "R3 ack on pulse");
    rd_exp('h08, 32'h0000_0001, "R3 frozen time");
    wr_reg('h08, 32'h0063_5958);
    rd_exp('h08, 32'h0023_5958, "R11 am/pm reads 0, load after ack");
    wr_reg('h0C, 32'h2862_2420);
    rd_exp('h0C, 32'h2862_2420, "R4 calendar load after ack");

    // R5 resume, R6 leap day, R7/R10/R9 interrupt path
    wr_reg('h00, 32'h0);
    wr_reg('h1C, 32'h1F);
    wr_reg('h20, 32'h10);
    rd_exp('h28, 32'h10, "R9 enable");
    chk_irq(1'b0, "R10 no event");
    pulse();
    rd_exp('h08, 32'h0023_5959, "R5 resume counting");
    rd_exp('h18, 32'h04, "R7 only second event");
    pulse();
    rd_exp('h08, 32'h0000_0000, "R2 midnight wrap");
    rd_exp('h0C, 32'h2982_2420, "R6 leap 29 Feb");
    rd_exp('h18, 32'h1C, "R7 minute and day events");
    chk_irq(1'b1, "R10 day event enabled");
    wr_reg('h24, 32'h10);
    rd_exp('h28, 32'h00, "R9 disable");
    chk_irq(1'b0, "R10 masked");
    wr_reg('h20, 32'h04);
    rd_exp('h28, 32'h04, "R9 enable second");
    chk_irq(1'b1, "R10 second event enabled");
    wr_reg('h1C, 32'h1F);
    chk_irq(1'b0, "R10 cleared");
    wr_reg('h24, 32'h1F);

    // R6 rollover corners
    load_all(32'h0023_5959, 32'h28E2_2320);
    pulse();
    rd_exp('h0C, 32'h0123_2320, "R6 non-leap Feb, weekday 7 wraps");
    load_all(32'h0023_5959, 32'h31B2_9920);
    pulse();
    rd_exp('h0C, 32'h01C1_0021, "R6 year 99 wraps, century up");
    load_all(32'h0023_5959, 32'h2822_0021);
    pulse();
    rd_exp('h0C, 32'h0143_0021, "R6 year 00 century 21 not leap");
    load_all(32'h0023_5959, 32'h2822_0020);
    pulse();
    rd_exp('h0C, 32'h2942_0020, "R6 year 00 century 20 leap");
    load_all(32'h0023_5959, 32'h3024_2420);
    pulse();
    rd_exp('h0C, 32'h0145_2420, "R6 30-day month");

    // R2 hour carry without day
    load_all(32'h0010_5959, 32'h0145_2420);
    pulse();
    rd_exp('h08, 32'h0011_0000, "R2 hour carry");
    rd_exp('h18, 32'h0C, "R7 minute event without day event");
    rd_exp('h0C, 32'h0145_2420, "R2 no day carry");

    // R11 mode fixed
    wr_reg('h04, 32'h1);
    rd_exp('h04, 32'h0, "R11 mode reads 0");

    // R3 / R4 / R5 time-only freeze
    wr_reg('h1C, 32'h1F);
    wr_reg('h00, 32'h1);
    pulse();
    rd_exp('h18, 32'h01, "R3 ack for time-only request");
    rd_exp('h08, 32'h0011_0000, "R3 time frozen");
    wr_reg('h0C, 32'h1522_1020);
    rd_exp('h0C, 32'h0145_2420, "R4 calendar not requested");
    wr_reg('h00, 32'h0);
    pulse();
    rd_exp('h08, 32'h0011_0001, "R5 resume after clear");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++;
      n_err++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule